// File: doc/BRIEF.md
# Link Start-up and Sleep Sequencer

This block owns the power state of the host end of a two-line serial display link (one clock line, one data line). After a power-down request is released it walks both lines through a fixed, timed wake-up ritual so that the far end can detect a fresh link start. Only then does it declare the link ready for frames. In the other direction it takes the link back to the all-off state when the host asks for power-down or when the reference clock disappears. A running transfer is never cut off: the bus must first have been quiet for a minimum number of link clock cycles.

The block runs on the link clock. The reference clock reaches it only as a sampled level (`ref_lvl`). Each rising edge of that level counts as one reference-clock period for the start-up timers. A level that stops changing marks the reference clock as stopped. The analog line drivers and the PLL are controlled only through the coded line-state outputs and the `sleep_req` enable. Frame requests reach the serializer only through a gate that is open while the link is ready. The block also holds a sticky link-error flag, which is cleared each time the link passes through the off state.

States: `ST_OFF` (sleep, both lines off), `ST_CK_PULSE`, `ST_CK_LOW`, `ST_CK_RUN`, `ST_DT_PULSE`, `ST_DT_LOW`, `ST_DT_HIGH` (the six timed wake-up phases, in that order), `ST_IDLE` (ready) and `ST_DRAIN` (waiting for a quiet bus before sleep). Transitions:
- `ST_OFF` to `ST_CK_PULSE` when `pd_n` is high and the reference clock runs.
- Each wake-up phase to the next phase on its last counted reference edge, and `ST_DT_HIGH` to `ST_IDLE`.
- Any wake-up phase to `ST_OFF` at once on a sleep cause.
- `ST_IDLE` to `ST_DRAIN` on a sleep cause.
- `ST_DRAIN` to `ST_OFF` once the bus has been quiet for long enough.

Top module: `link_wake_seq`

## Requirements
- R1: Reset puts the block in the off state. While it is off, `sleep_req` is 1, `link_ready` is 0 and both `ck_line` and `dt_line` read 0 (off). It stays off for as long as `pd_n` is low.
- R2: After leaving the off state the outputs step through six phases, each lasting a set number of reference rising edges: clock pulse (`ck_line`=1, `dt_line`=0) for 128, clock low (0,0) for 128, clock running (2,0) for 504, data pulse (2,1) for 128, data low (2,0) for 8, and data high (2,2) for 128. `ck_line` codes: 0 off, 1 pulse, 2 running. `dt_line` codes: 0 off, 1 pulse, 2 driven high.
- R3: After the 1024th reference rising edge of the sequence, `link_ready` is 1 with `ck_line`=2 and `dt_line`=2. The link stays in that idle state until a sleep cause appears.
- R4: `frame_go` follows `frame_req` only while `link_ready` is 1. A request made during start-up, drain or sleep is dropped.
- R5: When `pd_n` falls while the link is ready, `link_ready` drops at once but the lines stay running (2,2). The off state is entered on the clock edge after `bus_idle` has been 1 for 100 consecutive link clock edges.
- R6: A reference level that shows no change for 4 consecutive link clock samples counts as a stopped clock. It is a sleep cause, handled the same way as `pd_n` low.
- R7: A sleep cause that appears during any start-up phase returns the block to the off state on the next clock edge.
- R8: Every exit from the off state restarts the full sequence from the clock-pulse phase.
- R9: `err_flag` goes to 1 on the clock edge after `err_in` is 1 and stays set. It is cleared on the edge after the off state is entered, and `err_in` has no effect while the block is off.
- R10: The off state is left only when `pd_n` is high and the reference clock is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_n | input | 1 | Power-down request, active low |
| ref_lvl | input | 1 | Reference clock level as sampled in the link domain |
| bus_idle | input | 1 | 1 while no frame is in flight on the link |
| frame_req | input | 1 | Request to start a frame |
| err_in | input | 1 | Link error event |
| ck_line | output | 2 | Clock-line state: 0 off, 1 pulse, 2 running |
| dt_line | output | 2 | Data-line state: 0 off, 1 pulse, 2 driven high |
| link_ready | output | 1 | Start-up complete, link idle and usable |
| sleep_req | output | 1 | Sleep request; also disables PLL and drivers |
| frame_go | output | 1 | Gated frame request towards the serializer |
| err_flag | output | 1 | Sticky link error flag |

## Verification
The line-state outputs, `link_ready` and `sleep_req` are decoded from the state register, so they change one edge after the input that causes the change. `frame_go` follows `frame_req` in the same cycle. `err_flag` shows an `err_in` pulse one edge later. The bench drives inputs on falling edges and samples on later falling edges. It measures the length of every wake-up phase in whole cycles. The reference level rises every second link cycle, so each phase lasts twice its edge count, and only the first phase may be one cycle shorter. The drain rule is sampled exactly 100 and 101 edges after `bus_idle` rises. The stopped-clock case is checked with a margin window on both sides.

// File: rtl/lss_pkg.sv
package lss_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_CK_PULSE,
        ST_CK_LOW,
        ST_CK_RUN,
        ST_DT_PULSE,
        ST_DT_LOW,
        ST_DT_HIGH,
        ST_IDLE,
        ST_DRAIN
    } seq_state_e;

    localparam logic [1:0] CK_OFF   = 2'd0;
    localparam logic [1:0] CK_PULSE = 2'd1;
    localparam logic [1:0] CK_RUN   = 2'd2;

    localparam logic [1:0] DT_OFF   = 2'd0;
    localparam logic [1:0] DT_PULSE = 2'd1;
    localparam logic [1:0] DT_HIGH  = 2'd2;

endpackage

// File: rtl/lss_ref_watch.sv
module lss_ref_watch #(
    parameter int unsigned STOP_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_lvl,
    output logic ref_rise,
    output logic ref_stopped
);
    localparam int unsigned SW = $clog2(STOP_N + 1);

    logic          ref_q;
    logic [SW-1:0] stall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            stall <= '0;
        end else begin
            ref_q <= ref_lvl;
            if (ref_lvl != ref_q) begin
                stall <= '0;
            end else if (stall != SW'(STOP_N)) begin
                stall <= stall + 1'b1;
            end
        end
    end

    assign ref_rise    = ref_lvl & ~ref_q;
    assign ref_stopped = (stall == SW'(STOP_N));

endmodule

// File: rtl/lss_idle_meter.sv
module lss_idle_meter #(
    parameter int unsigned IDLE_MIN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    output logic idle_ok
);
    localparam int unsigned IW = $clog2(IDLE_MIN + 1);

    logic [IW-1:0] quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet <= '0;
        end else if (!bus_idle) begin
            quiet <= '0;
        end else if (quiet != IW'(IDLE_MIN)) begin
            quiet <= quiet + 1'b1;
        end
    end

    assign idle_ok = (quiet == IW'(IDLE_MIN));

endmodule

// File: rtl/lss_phase_fsm.sv
module lss_phase_fsm
    import lss_pkg::*;
#(
    parameter int unsigned CK_PULSE_LEN = 128,
    parameter int unsigned CK_LOW_LEN   = 128,
    parameter int unsigned CK_RUN_LEN   = 504,
    parameter int unsigned DT_PULSE_LEN = 128,
    parameter int unsigned DT_LOW_LEN   = 8,
    parameter int unsigned DT_HIGH_LEN  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_ok,
    input  logic       go_sleep,
    input  logic       drain_done,
    input  logic       ref_rise,
    output logic [1:0] ck_line,
    output logic [1:0] dt_line,
    output logic       link_ready,
    output logic       sleep_req
);
    localparam int unsigned M1   = (CK_PULSE_LEN > CK_LOW_LEN) ? CK_PULSE_LEN : CK_LOW_LEN;
    localparam int unsigned M2   = (CK_RUN_LEN > DT_PULSE_LEN) ? CK_RUN_LEN : DT_PULSE_LEN;
    localparam int unsigned M3   = (DT_LOW_LEN > DT_HIGH_LEN) ? DT_LOW_LEN : DT_HIGH_LEN;
    localparam int unsigned M12  = (M1 > M2) ? M1 : M2;
    localparam int unsigned MAXL = (M12 > M3) ? M12 : M3;
    localparam int unsigned TW   = $clog2(MAXL + 1);

    seq_state_e  state, state_n;
    logic [TW-1:0] tmr;
    int unsigned cur_len;
    logic        in_startup;
    logic        last_tick;

    always_comb begin
        unique case (state)
            ST_CK_PULSE: cur_len = CK_PULSE_LEN;
            ST_CK_LOW:   cur_len = CK_LOW_LEN;
            ST_CK_RUN:   cur_len = CK_RUN_LEN;
            ST_DT_PULSE: cur_len = DT_PULSE_LEN;
            ST_DT_LOW:   cur_len = DT_LOW_LEN;
            ST_DT_HIGH:  cur_len = DT_HIGH_LEN;
            default:     cur_len = 1;
        endcase
    end

    assign in_startup = (state inside {ST_CK_PULSE, ST_CK_LOW, ST_CK_RUN,
                                       ST_DT_PULSE, ST_DT_LOW, ST_DT_HIGH});
    assign last_tick  = ref_rise && (tmr == TW'(cur_len - 1));

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_OFF:      if (wake_ok) state_n = ST_CK_PULSE;
            ST_CK_PULSE: if (go_sleep) state_n = ST_OFF;
                         else if (last_tick) state_n = ST_CK_LOW;
            ST_CK_LOW:   if (go_sleep) state_n = ST_OFF;
                         else if (last_tick) state_n = ST_CK_RUN;
            ST_CK_RUN:   if (go_sleep) state_n = ST_OFF;
                         else if (last_tick) state_n = ST_DT_PULSE;
            ST_DT_PULSE: if (go_sleep) state_n = ST_OFF;
                         else if (last_tick) state_n = ST_DT_LOW;
            ST_DT_LOW:   if (go_sleep) state_n = ST_OFF;
                         else if (last_tick) state_n = ST_DT_HIGH;
            ST_DT_HIGH:  if (go_sleep) state_n = ST_OFF;
                         else if (last_tick) state_n = ST_IDLE;
            ST_IDLE:     if (go_sleep) state_n = ST_DRAIN;
            ST_DRAIN:    if (drain_done) state_n = ST_OFF;
            default:     state_n = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_n;
        end
    end

    // per-phase reference edge timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (state_n != state) begin
            tmr <= '0;
        end else if (in_startup && ref_rise) begin
            tmr <= tmr + 1'b1;
        end
    end

    // output decode
    always_comb begin
        ck_line    = CK_OFF;
        dt_line    = DT_OFF;
        link_ready = 1'b0;
        sleep_req  = 1'b0;
        unique case (state)
            ST_OFF:      sleep_req = 1'b1;
            ST_CK_PULSE: ck_line = CK_PULSE;
            ST_CK_LOW:   ck_line = CK_OFF;
            ST_CK_RUN:   ck_line = CK_RUN;
            ST_DT_PULSE: begin ck_line = CK_RUN; dt_line = DT_PULSE; end
            ST_DT_LOW:   ck_line = CK_RUN;
            ST_DT_HIGH:  begin ck_line = CK_RUN; dt_line = DT_HIGH; end
            ST_IDLE:     begin ck_line = CK_RUN; dt_line = DT_HIGH; link_ready = 1'b1; end
            ST_DRAIN:    begin ck_line = CK_RUN; dt_line = DT_HIGH; end
            default:     sleep_req = 1'b1;
        endcase
    end

endmodule

// File: rtl/link_wake_seq.sv
module link_wake_seq #(
    parameter int unsigned CK_PULSE_LEN = 128,
    parameter int unsigned CK_LOW_LEN   = 128,
    parameter int unsigned CK_RUN_LEN   = 504,
    parameter int unsigned DT_PULSE_LEN = 128,
    parameter int unsigned DT_LOW_LEN   = 8,
    parameter int unsigned DT_HIGH_LEN  = 128,
    parameter int unsigned STOP_N       = 4,
    parameter int unsigned IDLE_MIN     = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_n,
    input  logic       ref_lvl,
    input  logic       bus_idle,
    input  logic       frame_req,
    input  logic       err_in,
    output logic [1:0] ck_line,
    output logic [1:0] dt_line,
    output logic       link_ready,
    output logic       sleep_req,
    output logic       frame_go,
    output logic       err_flag
);
    logic ref_rise, ref_stopped, idle_ok;
    logic go_sleep, wake_ok;

    lss_ref_watch #(.STOP_N(STOP_N)) u_ref (
        .clk(clk), .rst_n(rst_n), .ref_lvl(ref_lvl),
        .ref_rise(ref_rise), .ref_stopped(ref_stopped)
    );

    lss_idle_meter #(.IDLE_MIN(IDLE_MIN)) u_idle (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .idle_ok(idle_ok)
    );

    assign go_sleep = !pd_n || ref_stopped;
    assign wake_ok  = pd_n && !ref_stopped;

    lss_phase_fsm #(
        .CK_PULSE_LEN(CK_PULSE_LEN), .CK_LOW_LEN(CK_LOW_LEN),
        .CK_RUN_LEN(CK_RUN_LEN),     .DT_PULSE_LEN(DT_PULSE_LEN),
        .DT_LOW_LEN(DT_LOW_LEN),     .DT_HIGH_LEN(DT_HIGH_LEN)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wake_ok(wake_ok), .go_sleep(go_sleep), .drain_done(idle_ok),
        .ref_rise(ref_rise),
        .ck_line(ck_line), .dt_line(dt_line),
        .link_ready(link_ready), .sleep_req(sleep_req)
    );

    // R4: frames pass only once the link is ready
    assign frame_go = frame_req & link_ready;

    // R9: sticky error, cleared while off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (sleep_req) begin
            err_flag <= 1'b0;
        end else if (err_in) begin
            err_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/link_wake_seq_chk.sv
module link_wake_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_n,
    input logic       frame_req,
    input logic [1:0] ck_line,
    input logic [1:0] dt_line,
    input logic       link_ready,
    input logic       sleep_req,
    input logic       frame_go,
    input logic       err_flag
);
    a_r1_off_lines: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (ck_line == 2'd0 && dt_line == 2'd0 && !link_ready));

    a_r1_pd_keeps_off: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !pd_n) |=> sleep_req);

    a_r3_ready_lines: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready |-> (ck_line == 2'd2 && dt_line == 2'd2));

    a_r2_ready_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> ($past(dt_line) == 2'd2 && $past(ck_line) == 2'd2));

    a_r4_drop_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_req && !link_ready) |-> !frame_go);

    a_r9_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !err_flag);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !sleep_req) |=> err_flag);

endmodule

bind link_wake_seq link_wake_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .frame_req(frame_req),
    .ck_line(ck_line), .dt_line(dt_line), .link_ready(link_ready),
    .sleep_req(sleep_req), .frame_go(frame_go), .err_flag(err_flag)
);

// File: tb/link_wake_seq_test.sv
module link_wake_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_n = 1'b0;
    logic       ref_lvl = 1'b0;
    logic       ref_run = 1'b1;
    logic       bus_idle = 1'b1;
    logic       frame_req = 1'b0;
    logic       err_in = 1'b0;
    logic [1:0] ck_line, dt_line;
    logic       link_ready, sleep_req, frame_go, err_flag;

    int nvec = 0;
    int nbad = 0;
    int cyc  = 0;
    logic exp_err = 1'b0;

    localparam int LEN [6] = '{128, 128, 504, 128, 8, 128};

    always #2 clk = ~clk;

    always @(negedge clk) if (ref_run) ref_lvl <= ~ref_lvl;

    link_wake_seq uut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .ref_lvl(ref_lvl),
        .bus_idle(bus_idle), .frame_req(frame_req), .err_in(err_in),
        .ck_line(ck_line), .dt_line(dt_line), .link_ready(link_ready),
        .sleep_req(sleep_req), .frame_go(frame_go), .err_flag(err_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_code(input int p);
        case (p)
            0: exp_code = {1'b0, 2'd1, 2'd0};
            1: exp_code = {1'b0, 2'd0, 2'd0};
            2: exp_code = {1'b0, 2'd2, 2'd0};
            3: exp_code = {1'b0, 2'd2, 2'd1};
            4: exp_code = {1'b0, 2'd2, 2'd0};
            default: exp_code = {1'b0, 2'd2, 2'd2};
        endcase
    endfunction

    // Measure the six phases after a wake; ref rises every 2 link cycles.
    task automatic measure_startup(input string t_phase, input string t_ready,
                                   input string t_drop);
        int to = 0;
        int cnt;
        int total = 0;
        int bad_go = 0;
        while (sleep_req && to < 50) begin
            @(negedge clk);
            to++;
        end
        check(t_phase, int'(sleep_req), 0);
        for (int p = 0; p < 6; p++) begin
            cnt = 0;
            while ({link_ready, ck_line, dt_line} == exp_code(p) && cnt < 4000) begin
                if (frame_go) bad_go++;
                cnt++;
                @(negedge clk);
            end
            total += cnt;
            if (p == 0)
                check(t_phase, cnt, (cnt == 2*LEN[0]-1) ? cnt : 2*LEN[0]);
            else
                check(t_phase, cnt, 2*LEN[p]);
        end
        check(t_ready, int'({link_ready, ck_line, dt_line}), int'(5'b11010));
        check(t_ready, int'(total >= 2047 && total <= 2048), 1);
        check(t_drop, bad_go, 0);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            nbad++;
            $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int wcnt;
        logic last_req;
        logic last_err;
        void'($urandom(32'd2718));

        // R1: reset and held power-down
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        frame_req = 1'b1;
        err_in = 1'b1;
        repeat (20) @(negedge clk);
        check("R1", int'(sleep_req), 1);
        check("R1", int'({link_ready, ck_line, dt_line}), 0);
        check("R4", int'(frame_go), 0);
        check("R9", int'(err_flag), 0);
        err_in = 1'b0;

        // R10: pd_n released while reference is stopped
        @(posedge clk);
        ref_run = 1'b0;
        @(negedge clk);
        pd_n = 1'b1;
        repeat (12) @(negedge clk);
        check("R10", int'(sleep_req), 1);
        @(posedge clk);
        ref_run = 1'b1;

        // R2, R3, R4: full start-up, frame requests held high throughout
        measure_startup("R2", "R3", "R4");

        // R4, R9: random traffic in the idle state
        last_req = frame_req;
        last_err = 1'b0;
        exp_err = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (i > 0) begin
                exp_err = exp_err | last_err;
                check("R4", int'(frame_go), int'(last_req));
                check("R9", int'(err_flag), int'(exp_err));
            end
            last_req  = 1'($urandom_range(0, 1));
            last_err  = (i == 5) ? 1'b1 : ($urandom_range(0, 31) == 0);
            frame_req = last_req;
            err_in    = last_err;
            bus_idle  = 1'($urandom_range(0, 1));
            @(negedge clk);
        end
        exp_err = exp_err | last_err;
        err_in = 1'b0;
        frame_req = 1'b0;

        // R5: power-down request with a busy bus
        bus_idle = 1'b0;
        pd_n = 1'b0;
        @(negedge clk);
        check("R9", int'(err_flag), int'(exp_err));
        wcnt = $urandom_range(30, 80);
        repeat (wcnt) @(negedge clk);
        check("R5", int'({link_ready, ck_line, dt_line, sleep_req}), int'(6'b0_10_10_0));
        bus_idle = 1'b1;
        repeat (100) @(negedge clk);
        check("R5", int'(sleep_req), 0);
        @(negedge clk);
        check("R5", int'(sleep_req), 1);
        check("R1", int'({ck_line, dt_line}), 0);
        @(negedge clk);
        check("R9", int'(err_flag), 0);
        err_in = 1'b1;
        @(negedge clk);
        err_in = 1'b0;
        check("R9", int'(err_flag), 0);
        repeat (5) @(negedge clk);
        check("R1", int'(sleep_req), 1);

        // R7: abort during the running-clock phase
        pd_n = 1'b1;
        wcnt = 0;
        while (!(ck_line == 2'd2 && dt_line == 2'd0) && wcnt < 2000) begin
            @(negedge clk);
            wcnt++;
        end
        repeat (20) @(negedge clk);
        check("R7", int'(sleep_req), 0);
        pd_n = 1'b0;
        @(negedge clk);
        check("R7", int'(sleep_req), 1);
        check("R7", int'({ck_line, dt_line}), 0);
        repeat (4) @(negedge clk);

        // R8: wake again and the whole sequence reruns
        pd_n = 1'b1;
        measure_startup("R8", "R8", "R4");

        // R6: reference clock stops with a long-quiet bus
        repeat (10) @(negedge clk);
        @(posedge clk);
        ref_run = 1'b0;
        repeat (2) @(negedge clk);
        check("R6", int'(sleep_req), 0);
        repeat (10) @(negedge clk);
        check("R6", int'(sleep_req), 1);
        repeat (10) @(negedge clk);
        check("R10", int'(sleep_req), 1);

        // R10: reference returns, wake follows
        @(posedge clk);
        ref_run = 1'b1;
        repeat (6) @(negedge clk);
        check("R10", int'(sleep_req), 0);
        check("R8", int'(ck_line), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule